// File: doc/BRIEF.md
# Transceiver Reconfiguration Handshake Controller

This block answers reconfiguration requests from a link-layer core on the user side of a serial link. There are three request channels. The first asks for a receive link-rate change. The second asks for a transmit link-rate change. The third asks for a change to the transmit analog drive settings: voltage swing and pre-emphasis. Each channel has a request input, an acknowledge output and a busy output. The core raises a request. The controller answers with a one-cycle acknowledge, then holds busy high for as long as the reconfiguration runs.

The transceiver programming itself is done by an external engine. When a job starts, the controller gives the engine a one-cycle start pulse, a channel code and the parameters it latched. It then waits for the engine's done input before it drops busy.

Only one job runs at a time. Requests that arrive together, or that arrive while a job runs, are served one after another in a fixed priority order. A request that is still high after its own job has finished is not served again until the core has first taken it low.

Top module: `xcvr_reconf_ctrl`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first cycle after it is released, all acknowledge outputs, all busy outputs and `eng_start` are low.
- R2: When the controller is idle and a request is pending, the acknowledge of the channel it selects is high for exactly one clock cycle. That cycle starts at the first clock edge that samples the request.
- R3: On the cycle after an acknowledge, the busy output of the same channel goes high and `eng_start` pulses high for exactly one cycle.
- R4: Busy stays high until `eng_done` is sampled high, and it falls at that same clock edge. `eng_done` has no effect while no job is running.
- R5: The job parameters are captured on the clock edge that raises the acknowledge. They stay stable on `eng_rate`, `eng_swing` and `eng_emph` while busy is high, even if the inputs change. The `eng_chan` code is 0 for receive rate, 1 for transmit rate and 2 for transmit analog. A rate value such as 1 (the HBR rate) is passed through unchanged.
- R6: When several requests are pending at once, the receive-rate channel is served first, then the transmit-rate channel, then the transmit-analog channel. Waiting requests are served later without being lost.
- R7: At most one busy output is high at any time. A request that arrives during a job gets no acknowledge until that job has finished.
- R8: A request that is still high when its busy falls gets no further acknowledge until it has gone low and then high again.
- R9: An analog job carries the 2-bit swing and 2-bit pre-emphasis values, including 00, and drives `eng_rate` to zero. A rate job drives `eng_swing` and `eng_emph` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxr_req | input | 1 | Receive link-rate change request |
| rxr_rate | input | RATE_W | Requested receive rate code |
| rxr_ack | output | 1 | Receive-rate acknowledge pulse |
| rxr_busy | output | 1 | Receive-rate reconfiguration in progress |
| txr_req | input | 1 | Transmit link-rate change request |
| txr_rate | input | RATE_W | Requested transmit rate code |
| txr_ack | output | 1 | Transmit-rate acknowledge pulse |
| txr_busy | output | 1 | Transmit-rate reconfiguration in progress |
| txa_req | input | 1 | Transmit analog setting change request |
| txa_swing | input | SWING_W | Requested voltage swing |
| txa_emph | input | EMPH_W | Requested pre-emphasis |
| txa_ack | output | 1 | Analog acknowledge pulse |
| txa_busy | output | 1 | Analog reconfiguration in progress |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_chan | output | 2 | Channel code of the running job |
| eng_rate | output | RATE_W | Latched rate code |
| eng_swing | output | SWING_W | Latched voltage swing |
| eng_emph | output | EMPH_W | Latched pre-emphasis |
| eng_done | input | 1 | Engine has finished the job |

## Verification
The hardest state to reach from the ports is three requests waiting at once while a job runs, combined with a served request that is held high across the fall of its own busy. The stimulus raises all three requests on the same clock edge and keeps every one of them high. It then finishes each job in turn, checking that the acknowledge moves down the priority order and never returns to a channel whose request stayed high. A separate scenario raises one request while another channel is in its acknowledge cycle, and it changes the parameter inputs in the middle of a job, to check that the request waits and that the latched values do not change.

// File: rtl/xrc_pkg.sv
package xrc_pkg;
   localparam int NUM_CH = 3;
   localparam int CH_W   = 2;

   typedef enum logic [CH_W-1:0] {
      CH_RX_RATE = 2'd0,
      CH_TX_RATE = 2'd1,
      CH_TX_ANA  = 2'd2
   } chan_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACK  = 2'd1,
      ST_RUN  = 2'd2
   } seq_e;
endpackage

// File: rtl/xrc_rearm.sv
// Per-channel request qualifier: a channel served once must see its
// request low before it may be offered to the arbiter again.
module xrc_rearm (
   input  logic clk,
   input  logic rst,
   input  logic req,
   input  logic grant,
   output logic pending
);
   logic armed_q;

   always_ff @(posedge clk) begin
      if (rst)        armed_q <= 1'b1;
      else if (grant) armed_q <= 1'b0;
      else if (!req)  armed_q <= 1'b1;
   end

   assign pending = armed_q & req;
endmodule

// File: rtl/xrc_prio_arb.sv
// Fixed-priority pick: lowest index wins.
module xrc_prio_arb #(
   parameter int N     = 3,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     win_onehot,
   output logic [IDX_W-1:0] win_idx,
   output logic             any
);
   if (N < 2) begin : g_bad_n
      $error("xrc_prio_arb: N must be at least 2");
   end

   assign win_onehot = req & ~(req - N'(1));
   assign any        = |req;

   always_comb begin
      win_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) win_idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/xrc_seq.sv
// Handshake sequencer: idle -> ack pulse -> run until engine done.
module xrc_seq
   import xrc_pkg::*;
#(
   parameter int N = NUM_CH
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            pend_any,
   input  logic [N-1:0]    win_onehot,
   input  logic [CH_W-1:0] win_idx,
   input  logic            done,
   output logic            grant,
   output logic [N-1:0]    ack,
   output logic [N-1:0]    busy,
   output logic            start,
   output logic [CH_W-1:0] chan
);
   seq_e            st_q;
   logic [N-1:0]    ack_q, busy_q;
   logic            start_q;
   logic [CH_W-1:0] chan_q;

   assign grant = (st_q == ST_IDLE) && pend_any;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= ST_IDLE;
         ack_q   <= '0;
         busy_q  <= '0;
         start_q <= 1'b0;
         chan_q  <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (grant) begin
                  ack_q  <= win_onehot;
                  chan_q <= win_idx;
                  st_q   <= ST_ACK;
               end
            end
            ST_ACK: begin
               ack_q   <= '0;
               busy_q  <= ack_q;
               start_q <= 1'b1;
               st_q    <= ST_RUN;
            end
            ST_RUN: begin
               start_q <= 1'b0;
               if (done) begin
                  busy_q <= '0;
                  st_q   <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign ack   = ack_q;
   assign busy  = busy_q;
   assign start = start_q;
   assign chan  = chan_q;

   // R2: acknowledge is a single-cycle pulse
   assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (rst)
      (|ack) |=> !(|ack));
   // R3: busy and start follow the acknowledge by one cycle
   assert_busy_after_ack_R3: assert property (@(posedge clk) disable iff (rst)
      (|ack) |=> ((busy == $past(ack)) && start));
   // R3: start lasts a single cycle
   assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
      start |=> !start);
   // R4: busy only falls after the engine reports done
   assert_busy_fall_done_R4: assert property (@(posedge clk) disable iff (rst)
      $fell(|busy) |-> $past(done));
   // R7: at most one reconfiguration runs at a time
   assert_one_busy_R7: assert property (@(posedge clk) disable iff (rst)
      $onehot0(busy) && $onehot0(ack) && !((|ack) && (|busy)));
endmodule

// File: rtl/xrc_param_hold.sv
// Captures the job parameters of the granted channel.
module xrc_param_hold
   import xrc_pkg::*;
#(
   parameter int RATE_W  = 8,
   parameter int SWING_W = 2,
   parameter int EMPH_W  = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               grant,
   input  logic [CH_W-1:0]    win_idx,
   input  logic [RATE_W-1:0]  rx_rate,
   input  logic [RATE_W-1:0]  tx_rate,
   input  logic [SWING_W-1:0] swing,
   input  logic [EMPH_W-1:0]  emph,
   output logic [RATE_W-1:0]  q_rate,
   output logic [SWING_W-1:0] q_swing,
   output logic [EMPH_W-1:0]  q_emph
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q_rate  <= '0;
         q_swing <= '0;
         q_emph  <= '0;
      end else if (grant) begin
         case (win_idx)
            CH_RX_RATE: begin
               q_rate <= rx_rate; q_swing <= '0; q_emph <= '0;
            end
            CH_TX_RATE: begin
               q_rate <= tx_rate; q_swing <= '0; q_emph <= '0;
            end
            default: begin
               q_rate <= '0; q_swing <= swing; q_emph <= emph;
            end
         endcase
      end
   end
endmodule

// File: rtl/xcvr_reconf_ctrl.sv
module xcvr_reconf_ctrl
   import xrc_pkg::*;
#(
   parameter int RATE_W  = 8,
   parameter int SWING_W = 2,
   parameter int EMPH_W  = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               rxr_req,
   input  logic [RATE_W-1:0]  rxr_rate,
   output logic               rxr_ack,
   output logic               rxr_busy,
   input  logic               txr_req,
   input  logic [RATE_W-1:0]  txr_rate,
   output logic               txr_ack,
   output logic               txr_busy,
   input  logic               txa_req,
   input  logic [SWING_W-1:0] txa_swing,
   input  logic [EMPH_W-1:0]  txa_emph,
   output logic               txa_ack,
   output logic               txa_busy,
   output logic               eng_start,
   output logic [CH_W-1:0]    eng_chan,
   output logic [RATE_W-1:0]  eng_rate,
   output logic [SWING_W-1:0] eng_swing,
   output logic [EMPH_W-1:0]  eng_emph,
   input  logic               eng_done
);
   if (RATE_W < 1 || SWING_W < 1 || EMPH_W < 1) begin : g_bad_width
      $error("xcvr_reconf_ctrl: field widths must be positive");
   end

   logic [NUM_CH-1:0] req_v, pend_v, win_oh, ack_v, busy_v;
   logic [CH_W-1:0]   win_idx;
   logic              pend_any, grant;

   assign req_v = {txa_req, txr_req, rxr_req};

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      xrc_rearm u_rearm (
         .clk     (clk),
         .rst     (rst),
         .req     (req_v[c]),
         .grant   (grant && win_oh[c]),
         .pending (pend_v[c])
      );

      // R8: a request held across busy falling is not acknowledged again
      assert_no_reserve_R8: assert property (@(posedge clk) disable iff (rst)
         ($fell(busy_v[c]) && req_v[c]) |=> !ack_v[c]);
   end

   xrc_prio_arb #(.N(NUM_CH)) u_arb (
      .req        (pend_v),
      .win_onehot (win_oh),
      .win_idx    (win_idx),
      .any        (pend_any)
   );

   xrc_seq #(.N(NUM_CH)) u_seq (
      .clk        (clk),
      .rst        (rst),
      .pend_any   (pend_any),
      .win_onehot (win_oh),
      .win_idx    (win_idx),
      .done       (eng_done),
      .grant      (grant),
      .ack        (ack_v),
      .busy       (busy_v),
      .start      (eng_start),
      .chan       (eng_chan)
   );

   xrc_param_hold #(.RATE_W(RATE_W), .SWING_W(SWING_W), .EMPH_W(EMPH_W)) u_hold (
      .clk     (clk),
      .rst     (rst),
      .grant   (grant),
      .win_idx (win_idx),
      .rx_rate (rxr_rate),
      .tx_rate (txr_rate),
      .swing   (txa_swing),
      .emph    (txa_emph),
      .q_rate  (eng_rate),
      .q_swing (eng_swing),
      .q_emph  (eng_emph)
   );

   assign {txa_ack,  txr_ack,  rxr_ack}  = ack_v;
   assign {txa_busy, txr_busy, rxr_busy} = busy_v;

   // R5: latched parameters do not move during a job
   assert_param_stable_R5: assert property (@(posedge clk) disable iff (rst)
      ((|busy_v) && $past(|busy_v)) |->
         ($stable(eng_rate) && $stable(eng_swing) && $stable(eng_emph) && $stable(eng_chan)));
   // R9: an analog job carries no rate, a rate job carries no analog values
   assert_field_split_R9: assert property (@(posedge clk) disable iff (rst)
      (|busy_v) |-> (txa_busy ? (eng_rate == '0) : (eng_swing == '0 && eng_emph == '0)));
endmodule

// File: tb/xcvr_reconf_ctrl_test.sv
`timescale 1ns/1ps
module xcvr_reconf_ctrl_test;
   localparam int RW = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic rxr_req = 0, txr_req = 0, txa_req = 0, eng_done = 0;
   logic [RW-1:0] rxr_rate = '0, txr_rate = '0;
   logic [1:0] txa_swing = '0, txa_emph = '0;
   logic rxr_ack, rxr_busy, txr_ack, txr_busy, txa_ack, txa_busy, eng_start;
   logic [1:0] eng_chan, eng_swing, eng_emph;
   logic [RW-1:0] eng_rate;
   logic [2:0] acks, busys;

   int total = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   xcvr_reconf_ctrl #(.RATE_W(RW)) uut (
      .clk(clk), .rst(rst),
      .rxr_req(rxr_req), .rxr_rate(rxr_rate), .rxr_ack(rxr_ack), .rxr_busy(rxr_busy),
      .txr_req(txr_req), .txr_rate(txr_rate), .txr_ack(txr_ack), .txr_busy(txr_busy),
      .txa_req(txa_req), .txa_swing(txa_swing), .txa_emph(txa_emph),
      .txa_ack(txa_ack), .txa_busy(txa_busy),
      .eng_start(eng_start), .eng_chan(eng_chan), .eng_rate(eng_rate),
      .eng_swing(eng_swing), .eng_emph(eng_emph), .eng_done(eng_done)
   );

   assign acks  = {txa_ack, txr_ack, rxr_ack};
   assign busys = {txa_busy, txr_busy, rxr_busy};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Called at a negedge after the request was driven; the next edge grants.
   task automatic serve(input int ch, input int rate, input int sw, input int em,
                        input int hold);
      @(negedge clk);
      chk("R2 ack selected channel", acks, 32'(1 << ch));
      chk("R5 channel code", eng_chan, ch);
      chk("R5 latched rate", eng_rate, rate);
      chk("R9 latched swing", eng_swing, sw);
      chk("R9 latched emph", eng_emph, em);
      @(negedge clk);
      chk("R2 ack one cycle", acks, 0);
      chk("R3 busy after ack", busys, 32'(1 << ch));
      chk("R3 start pulse", eng_start, 1);
      @(negedge clk);
      chk("R3 start low again", eng_start, 0);
      rxr_rate = ~rxr_rate; txr_rate = ~txr_rate;
      txa_swing = ~txa_swing; txa_emph = ~txa_emph;
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         chk("R4 busy held", busys, 32'(1 << ch));
         chk("R5 rate stable", eng_rate, rate);
         chk("R5 swing/emph stable", {eng_swing, eng_emph}, {sw[1:0], em[1:0]});
      end
      eng_done = 1;
      @(negedge clk);
      eng_done = 0;
      chk("R4 busy falls on done", busys, 0);
   endtask

   task automatic t_reset;
      chk("R1 ack in reset", acks, 0);
      chk("R1 busy in reset", busys, 0);
      rst = 0;
      @(negedge clk);
      chk("R1 ack after reset", acks, 0);
      chk("R1 busy after reset", busys, 0);
      chk("R1 start after reset", eng_start, 0);
   endtask

   task automatic t_rx_hbr;
      rxr_rate = 8'd1; rxr_req = 1;
      serve(0, 1, 0, 0, 2);
      rxr_req = 0;
      @(negedge clk);
   endtask

   task automatic t_done_idle;
      eng_done = 1;
      @(negedge clk);
      eng_done = 0;
      chk("R4 done ignored busy", busys, 0);
      chk("R4 done ignored ack", acks, 0);
      chk("R4 done ignored start", eng_start, 0);
   endtask

   task automatic t_tx_rate;
      txr_rate = 8'h5a; txr_req = 1;
      serve(1, 8'h5a, 0, 0, 5);
      txr_req = 0;
      @(negedge clk);
   endtask

   task automatic t_analog;
      txa_swing = 2'b00; txa_emph = 2'b00; txa_req = 1;
      serve(2, 0, 0, 0, 1);
      txa_req = 0;
      @(negedge clk);
      txa_swing = 2'b10; txa_emph = 2'b01; txa_req = 1;
      serve(2, 0, 2, 1, 1);
      txa_req = 0;
      @(negedge clk);
   endtask

   task automatic t_priority;
      rxr_rate = 8'd3; txr_rate = 8'd2; txa_swing = 2'b11; txa_emph = 2'b10;
      rxr_req = 1; txr_req = 1; txa_req = 1;
      serve(0, 3, 0, 0, 1);
      // R6: the waiting transmit-rate request is next; its rate input was flipped
      serve(1, 8'hfd, 0, 0, 1);
      // R6: analog last; swing/emph were flipped twice
      serve(2, 0, 3, 2, 1);
      @(negedge clk);
      chk("R8 none re-served after all", acks, 0);
      rxr_req = 0; txr_req = 0; txa_req = 0;
      @(negedge clk);
   endtask

   task automatic t_rearm;
      rxr_rate = 8'd1; rxr_req = 1;
      serve(0, 1, 0, 0, 0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R8 held request not re-served", acks, 0);
         chk("R8 no busy while held", busys, 0);
      end
      rxr_req = 0;
      @(negedge clk);
      rxr_rate = 8'd2; rxr_req = 1;
      serve(0, 2, 0, 0, 0);
      rxr_req = 0;
      @(negedge clk);
   endtask

   task automatic t_late;
      rxr_rate = 8'd1; rxr_req = 1;
      @(negedge clk);
      chk("R7 rx ack", acks, 3'b001);
      txr_rate = 8'd7; txr_req = 1;
      @(negedge clk);
      chk("R7 rx busy, tx waits", {busys, acks}, {3'b001, 3'b000});
      @(negedge clk);
      @(negedge clk);
      chk("R7 tx no ack during job", acks, 0);
      eng_done = 1;
      @(negedge clk);
      eng_done = 0;
      chk("R7 rx done", busys, 0);
      chk("R7 tx not yet acked", acks, 0);
      serve(1, 7, 0, 0, 0);
      rxr_req = 0; txr_req = 0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_rx_hbr();
      t_done_idle();
      t_tx_rate();
      t_analog();
      t_priority();
      t_rearm();
      t_late();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #100000;
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule